// File: doc/BRIEF.md
# Paged DMA Channel Address Generator

This block produces one memory address per DMA transfer step for a small set of channels. Each channel holds a 16-bit address register, a 16-bit count register, a transfer-type field and a decrement bit. These are loaded through a setup port. A requester presents a channel number and a direction. The direction is either a device-to-memory write or a memory-to-device read. One clock later the block answers with one of three results: rejection, acceptance, or acceptance with end-of-process. An accepted step also returns a 24-bit physical address.

The upper byte of the physical address comes from a page register file of sixteen bytes. Software reaches this file through sixteen I/O port offsets, and the mapping from port offset to storage slot is scrambled. Each channel takes its page byte from the slot whose index equals its channel number. The upper eight port offsets belong to an extended system. When the extended-system input is low, those offsets are refused and an unhandled-access pulse is raised.

Top module: `paged_dma_agen`

## Requirements
- R1: A write step is accepted only when the channel's transfer type is 1 (write). A read step is accepted only when the type is 2 (read). Types 0 (verify) and 3 (invalid) reject both directions. A rejected step changes no channel address, count or terminal-count state.
- R2: An accepted step returns the channel's current address. It then increments the address by one, or decrements it by one when the decrement bit is set. Both directions wrap modulo 2^16.
- R3: Every accepted step lowers the count by one, modulo 2^16. The channel's terminal-count flag sets when the count becomes 0xFFFF. A setup write to a channel clears its flag.
- R4: The result is end-of-process (code 2) only on the step that moves the terminal-count flag from clear to set. Every other accepted step gives code 1.
- R5: For an accepted step, `res_addr[23:16]` is the page byte in the storage slot equal to the channel number, and `res_addr[15:0]` is the channel address. A rejected step returns `res_addr` = 0.
- R6: Port offsets map to storage slots as follows: 0→4, 1→2, 2→3, 3→1, 4→8, 5→9, 6→10, 7→0, 8→11, 9→6, 10→7, 11→5, 12→12, 13→13, 14→14, 15→15. All slots reset to 0. A read returns the stored byte on `io_rdata` one clock after `io_rd`.
- R7: While `ext_en` is low, a write to offsets 8 to 15 leaves storage unchanged and raises `io_unhandled` for exactly one clock, the clock after the write.
- R8: While `ext_en` is low, a read of offsets 8 to 15 returns 0xFF and raises `io_unhandled` for one clock. Accesses to offsets 0 to 7 never raise it.
- R9: `res_valid` is high exactly one clock after a cycle with `req` high. The result code is 0 rejected, 1 accepted, 2 accepted with end-of-process. Outside valid cycles the code is 0 and the address is 0.
- R10: A setup write loads the selected channel's address, count, transfer type and decrement bit, and the channel uses them on its next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Extended-system flag; enables page port offsets 8 to 15 |
| cfg_we | input | 1 | Channel setup strobe |
| cfg_chan | input | 2 | Channel being set up |
| cfg_addr | input | 16 | Start address to load |
| cfg_count | input | 16 | Count to load |
| cfg_xfer | input | 2 | Transfer type: 0 verify, 1 write, 2 read, 3 invalid |
| cfg_dec | input | 1 | 1 selects address decrement |
| req | input | 1 | Step request strobe |
| req_chan | input | 2 | Channel for the step |
| req_write | input | 1 | 1 for a write step, 0 for a read step |
| res_valid | output | 1 | Result valid, one clock after req |
| res_code | output | 2 | 0 rejected, 1 accepted, 2 accepted with end-of-process |
| res_addr | output | 24 | Physical address: page byte and channel address |
| io_wr | input | 1 | Page port write strobe |
| io_rd | input | 1 | Page port read strobe |
| io_off | input | 4 | Page port offset |
| io_wdata | input | 8 | Page port write data |
| io_rdata | output | 8 | Page port read data, one clock after io_rd |
| io_unhandled | output | 1 | One-clock pulse for a refused gated access |

## Verification
An ascending run of write steps from a count of two shows where end-of-process lands. It tells the single transition step apart from the steps before it and from the sticky steps after it. A count loaded as zero does the same check at the first step, and a reload shows the terminal-count flag clearing. Descending and ascending runs that cross 0x0000 and 0xFFFF check the wrap in each direction. Wrong-direction requests and the verify and invalid types, each followed by a valid step, show that a rejection leaves the address and count untouched. Writing a distinct byte to every page port and reading it back checks the scrambled slot mapping. Steps on different channels then show which slot each channel takes as its page. Accesses to the gated ports with the extended flag low and high separate a refused write from a stored one.

// File: rtl/dmapg_pkg.sv
package dmapg_pkg;

   typedef enum logic [1:0] {
      XFER_VERIFY  = 2'd0,
      XFER_WRITE   = 2'd1,
      XFER_READ    = 2'd2,
      XFER_ILLEGAL = 2'd3
   } xfer_e;

   typedef enum logic [1:0] {
      RES_REJECT = 2'd0,
      RES_OK     = 2'd1,
      RES_EOP    = 2'd2,
      RES_SPARE  = 2'd3
   } res_e;

   // Scrambled port-offset to storage-slot map of the page file.
   function automatic logic [3:0] slot_of(input logic [3:0] off);
      logic [3:0] s;
      case (off)
         4'd0:    s = 4'd4;
         4'd1:    s = 4'd2;
         4'd2:    s = 4'd3;
         4'd3:    s = 4'd1;
         4'd4:    s = 4'd8;
         4'd5:    s = 4'd9;
         4'd6:    s = 4'd10;
         4'd7:    s = 4'd0;
         4'd8:    s = 4'd11;
         4'd9:    s = 4'd6;
         4'd10:   s = 4'd7;
         4'd11:   s = 4'd5;
         default: s = off;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/dmapg_page_file.sv
module dmapg_page_file
   import dmapg_pkg::*;
#(
   parameter int PAGE_W  = 8,
   parameter int PORT_AW = 4,
   parameter int NUM_CH  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ext_en,
   input  logic                           io_wr,
   input  logic                           io_rd,
   input  logic [PORT_AW-1:0]             io_off,
   input  logic [PAGE_W-1:0]              io_wdata,
   output logic [PAGE_W-1:0]              io_rdata,
   output logic                           io_unhandled,
   output logic [NUM_CH-1:0][PAGE_W-1:0]  chan_page
);

   localparam int PAGE_SLOTS = 1 << PORT_AW;

   if (PORT_AW != 4) begin : g_bad_port_aw
      $error("dmapg_page_file: the slot map covers exactly 16 ports");
   end
   if (NUM_CH > PAGE_SLOTS) begin : g_bad_num_ch
      $error("dmapg_page_file: more channels than page slots");
   end

   logic [PAGE_SLOTS-1:0][PAGE_W-1:0] slots_q;
   logic                              gated;
   logic [PORT_AW-1:0]                slot_idx;

   assign gated    = io_off[PORT_AW-1] && !ext_en;
   assign slot_idx = slot_of(io_off);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slots_q      <= '0;
         io_rdata     <= '0;
         io_unhandled <= 1'b0;
      end else begin
         if (io_wr && !gated) begin
            slots_q[slot_idx] <= io_wdata;
         end
         if (io_rd) begin
            io_rdata <= gated ? {PAGE_W{1'b1}} : slots_q[slot_idx];
         end
         io_unhandled <= (io_wr || io_rd) && gated;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan_page
      assign chan_page[i] = slots_q[i];
   end

   assert_gate_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_rd && io_off[PORT_AW-1] && !ext_en) |=> ($stable(slots_q) && io_unhandled))
      else $error("gated page write altered storage");

   assert_gate_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_off[PORT_AW-1] && !ext_en) |=> (io_rdata == {PAGE_W{1'b1}} && io_unhandled))
      else $error("gated page read not refused");

   assert_low_ports_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !io_off[PORT_AW-1] |=> !io_unhandled)
      else $error("unhandled pulse on an ungated port");

endmodule

// File: rtl/dmapg_chan.sv
module dmapg_chan
   import dmapg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  xfer_e             cfg_xfer,
   input  logic              cfg_dec,
   input  logic              step_go,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output xfer_e             xfer_q,
   output logic              tc_q
);

   logic              dec_q;
   logic [CNT_W-1:0]  cnt_next;
   logic [ADDR_W-1:0] addr_next;

   assign cnt_next  = cnt_q - 1'b1;
   assign addr_next = dec_q ? (addr_q - 1'b1) : (addr_q + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         xfer_q <= XFER_VERIFY;
         dec_q  <= 1'b0;
         tc_q   <= 1'b0;
      end else if (cfg_we) begin
         addr_q <= cfg_addr;
         cnt_q  <= cfg_cnt;
         xfer_q <= cfg_xfer;
         dec_q  <= cfg_dec;
         tc_q   <= 1'b0;
      end else if (step_go) begin
         addr_q <= addr_next;
         cnt_q  <= cnt_next;
         if (cnt_next == {CNT_W{1'b1}}) begin
            tc_q <= 1'b1;
         end
      end
   end

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_go && !cfg_we) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(tc_q)))
      else $error("channel state moved without a step");

   assert_tc_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_q) |-> (cnt_q == {CNT_W{1'b1}}))
      else $error("terminal count set away from 0xFFFF");

   assert_tc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !tc_q)
      else $error("setup did not clear terminal count");

endmodule

// File: rtl/dmapg_step.sv
module dmapg_step
   import dmapg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req,
   input  logic                     req_write,
   input  xfer_e                    sel_xfer,
   input  logic [ADDR_W-1:0]        sel_addr,
   input  logic [CNT_W-1:0]         sel_cnt,
   input  logic                     sel_tc,
   input  logic [PAGE_W-1:0]        sel_page,
   output logic                     accept,
   output logic                     res_valid,
   output res_e                     res_code,
   output logic [PAGE_W+ADDR_W-1:0] res_phys
);

   logic type_ok;
   logic hits_tc;

   assign type_ok = req_write ? (sel_xfer == XFER_WRITE) : (sel_xfer == XFER_READ);
   assign accept  = req && type_ok;
   assign hits_tc = (sel_cnt == '0) && !sel_tc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= RES_REJECT;
         res_phys  <= '0;
      end else begin
         res_valid <= req;
         if (accept) begin
            res_code <= hits_tc ? RES_EOP : RES_OK;
            res_phys <= {sel_page, sel_addr};
         end else begin
            res_code <= RES_REJECT;
            res_phys <= '0;
         end
      end
   end

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> res_valid)
      else $error("no result one clock after request");

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!res_valid && res_code == RES_REJECT && res_phys == '0))
      else $error("result outputs active without request");

   assert_reject_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !type_ok) |=> (res_code == RES_REJECT && res_phys == '0))
      else $error("rejected step produced an address");

endmodule

// File: rtl/paged_dma_agen.sv
module paged_dma_agen
   import dmapg_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter int PAGE_W  = 8,
   parameter int PORT_AW = 4,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int PHYS_W = PAGE_W + ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_en,
   input  logic               cfg_we,
   input  logic [CH_W-1:0]    cfg_chan,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [CNT_W-1:0]   cfg_count,
   input  logic [1:0]         cfg_xfer,
   input  logic               cfg_dec,
   input  logic               req,
   input  logic [CH_W-1:0]    req_chan,
   input  logic               req_write,
   output logic               res_valid,
   output logic [1:0]         res_code,
   output logic [PHYS_W-1:0]  res_addr,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [PORT_AW-1:0] io_off,
   input  logic [PAGE_W-1:0]  io_wdata,
   output logic [PAGE_W-1:0]  io_rdata,
   output logic               io_unhandled
);

   if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_bad_num_ch
      $error("paged_dma_agen: NUM_CH must be a power of two of at least 2");
   end

   logic [NUM_CH-1:0][ADDR_W-1:0] addr_vec;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_vec;
   xfer_e                         xfer_vec [NUM_CH];
   logic [NUM_CH-1:0]             tc_vec;
   logic [NUM_CH-1:0][PAGE_W-1:0] page_vec;
   logic                          accept;
   res_e                          code_q;

   dmapg_page_file #(
      .PAGE_W  (PAGE_W),
      .PORT_AW (PORT_AW),
      .NUM_CH  (NUM_CH)
   ) u_pages (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_en       (ext_en),
      .io_wr        (io_wr),
      .io_rd        (io_rd),
      .io_off       (io_off),
      .io_wdata     (io_wdata),
      .io_rdata     (io_rdata),
      .io_unhandled (io_unhandled),
      .chan_page    (page_vec)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      logic ch_cfg;
      logic ch_go;
      assign ch_cfg = cfg_we && (cfg_chan == CH_W'(i));
      assign ch_go  = accept && (req_chan == CH_W'(i));

      dmapg_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (ch_cfg),
         .cfg_addr (cfg_addr),
         .cfg_cnt  (cfg_count),
         .cfg_xfer (xfer_e'(cfg_xfer)),
         .cfg_dec  (cfg_dec),
         .step_go  (ch_go),
         .addr_q   (addr_vec[i]),
         .cnt_q    (cnt_vec[i]),
         .xfer_q   (xfer_vec[i]),
         .tc_q     (tc_vec[i])
      );
   end

   dmapg_step #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .PAGE_W (PAGE_W)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_write (req_write),
      .sel_xfer  (xfer_vec[req_chan]),
      .sel_addr  (addr_vec[req_chan]),
      .sel_cnt   (cnt_vec[req_chan]),
      .sel_tc    (tc_vec[req_chan]),
      .sel_page  (page_vec[req_chan]),
      .accept    (accept),
      .res_valid (res_valid),
      .res_code  (code_q),
      .res_phys  (res_addr)
   );

   assign res_code = code_q;

   assert_eop_sets_tc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !cfg_we && tc_vec[req_chan]) |=> (res_code != 2'd2))
      else $error("end-of-process repeated after terminal count");

   assert_eop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd2) |-> tc_vec[$past(req_chan)])
      else $error("end-of-process without terminal count");

   assert_page_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && accept && !io_wr) |=> (res_addr[PHYS_W-1:ADDR_W] == $past(page_vec[req_chan])))
      else $error("physical address page byte mismatch");

endmodule

// File: tb/paged_dma_agen_bench.sv
`timescale 1ns/1ps
module paged_dma_agen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_en = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_chan = '0;
   logic [15:0] cfg_addr = '0;
   logic [15:0] cfg_count = '0;
   logic [1:0]  cfg_xfer = '0;
   logic        cfg_dec = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  req_chan = '0;
   logic        req_write = 1'b0;
   logic        res_valid;
   logic [1:0]  res_code;
   logic [23:0] res_addr;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [3:0]  io_off = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_unhandled;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   paged_dma_agen u_paged_dma_agen (
      .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
      .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_addr(cfg_addr),
      .cfg_count(cfg_count), .cfg_xfer(cfg_xfer), .cfg_dec(cfg_dec),
      .req(req), .req_chan(req_chan), .req_write(req_write),
      .res_valid(res_valid), .res_code(res_code), .res_addr(res_addr),
      .io_wr(io_wr), .io_rd(io_rd), .io_off(io_off), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_unhandled(io_unhandled)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setup(input logic [1:0] ch, input logic [15:0] a, input logic [15:0] n,
                        input logic [1:0] x, input logic d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_chan = ch; cfg_addr = a; cfg_count = n; cfg_xfer = x; cfg_dec = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pwrite(input logic [3:0] off, input logic [7:0] v);
      @(negedge clk);
      io_wr = 1'b1; io_off = off; io_wdata = v;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic pread(input logic [3:0] off, output logic [7:0] v, output logic u);
      @(negedge clk);
      io_rd = 1'b1; io_off = off;
      @(negedge clk);
      io_rd = 1'b0;
      v = io_rdata; u = io_unhandled;
   endtask

   // Result sampled at the falling edge after the registering edge.
   task automatic step(input logic [1:0] ch, input logic wr, input string tag,
                       input logic [1:0] exp_code, input logic [23:0] exp_addr);
      @(negedge clk);
      req = 1'b1; req_chan = ch; req_write = wr;
      @(negedge clk);
      req = 1'b0;
      chk({tag, " R9 valid"}, 32'(res_valid), 32'd1);
      chk({tag, " code"}, 32'(res_code), 32'(exp_code));
      chk({tag, " addr"}, 32'(res_addr), 32'(exp_addr));
   endtask

   task automatic t_reset();
      logic [7:0] v; logic u;
      chk("R9 reset valid", 32'(res_valid), 32'd0);
      chk("R9 reset code", 32'(res_code), 32'd0);
      pread(4'd5, v, u);
      chk("R6 reset slot zero", 32'(v), 32'd0);
      chk("R8 low port no unhandled", 32'(u), 32'd0);
   endtask

   task automatic t_write_run();
      pwrite(4'd3, 8'h5A);                       // port 3 -> slot 1 -> channel 1
      setup(2'd1, 16'h1234, 16'd2, 2'd1, 1'b0);  // R10
      step(2'd1, 1'b1, "R2 first", 2'd1, 24'h5A1234);
      step(2'd1, 1'b1, "R3 second", 2'd1, 24'h5A1235);
      step(2'd1, 1'b1, "R4 eop", 2'd2, 24'h5A1236);
      step(2'd1, 1'b1, "R4 sticky", 2'd1, 24'h5A1237);
      @(negedge clk);
      chk("R9 idle valid", 32'(res_valid), 32'd0);
   endtask

   task automatic t_reject();
      step(2'd1, 1'b0, "R1 wrong dir", 2'd0, 24'h0);
      step(2'd1, 1'b1, "R1 unchanged", 2'd1, 24'h5A1238);
      setup(2'd0, 16'h0040, 16'd0, 2'd0, 1'b0);
      step(2'd0, 1'b1, "R1 verify wr", 2'd0, 24'h0);
      step(2'd0, 1'b0, "R1 verify rd", 2'd0, 24'h0);
      setup(2'd0, 16'h0040, 16'd0, 2'd3, 1'b0);
      step(2'd0, 1'b1, "R1 invalid wr", 2'd0, 24'h0);
      step(2'd0, 1'b0, "R1 invalid rd", 2'd0, 24'h0);
   endtask

   task automatic t_wrap();
      pwrite(4'd2, 8'hC3);                       // port 2 -> slot 3 -> channel 3
      setup(2'd3, 16'h0001, 16'd10, 2'd2, 1'b1);
      step(2'd3, 1'b0, "R2 dec a", 2'd1, 24'hC30001);
      step(2'd3, 1'b0, "R2 dec b", 2'd1, 24'hC30000);
      step(2'd3, 1'b0, "R2 dec wrap", 2'd1, 24'hC3FFFF);
      setup(2'd1, 16'hFFFF, 16'd10, 2'd1, 1'b0);
      step(2'd1, 1'b1, "R2 inc a", 2'd1, 24'h5AFFFF);
      step(2'd1, 1'b1, "R2 inc wrap", 2'd1, 24'h5A0000);
   endtask

   task automatic t_page_map();
      logic [7:0] v; logic u;
      ext_en = 1'b1;
      for (int off = 0; off < 16; off++) begin
         pwrite(4'(off), 8'hA0 + 8'(off));
      end
      for (int off = 0; off < 16; off++) begin
         pread(4'(off), v, u);
         chk($sformatf("R6 readback port %0d", off), 32'(v), 32'hA0 + 32'(off));
      end
      setup(2'd0, 16'h0100, 16'd5, 2'd1, 1'b0);  // slot 0 <- port 7
      step(2'd0, 1'b1, "R5 ch0 page", 2'd1, 24'hA70100);
      setup(2'd2, 16'h0200, 16'd5, 2'd2, 1'b0);  // slot 2 <- port 1
      step(2'd2, 1'b0, "R5 ch2 page", 2'd1, 24'hA10200);
      step(2'd1, 1'b1, "R5 ch1 page", 2'd1, 24'hA30001); // slot 1 <- port 3
      step(2'd3, 1'b0, "R5 ch3 page", 2'd1, 24'hA2FFFE); // slot 3 <- port 2
   endtask

   task automatic t_gating();
      logic [7:0] v; logic u;
      ext_en = 1'b0;
      pwrite(4'd9, 8'h55);
      chk("R7 gated write pulse", 32'(io_unhandled), 32'd1);
      @(negedge clk);
      chk("R7 pulse one cycle", 32'(io_unhandled), 32'd0);
      pread(4'd9, v, u);
      chk("R8 gated read data", 32'(v), 32'hFF);
      chk("R8 gated read pulse", 32'(u), 32'd1);
      pread(4'd7, v, u);
      chk("R8 low port data", 32'(v), 32'hA7);
      chk("R8 low port no pulse", 32'(u), 32'd0);
      ext_en = 1'b1;
      pread(4'd9, v, u);
      chk("R7 write ignored", 32'(v), 32'hA9);
      chk("R7 ext no pulse", 32'(u), 32'd0);
   endtask

   task automatic t_zero_count();
      setup(2'd0, 16'h0010, 16'd0, 2'd1, 1'b0);
      step(2'd0, 1'b1, "R4 zero eop", 2'd2, 24'hA70010);
      step(2'd0, 1'b1, "R4 zero after", 2'd1, 24'hA70011);
      setup(2'd0, 16'h0020, 16'd1, 2'd1, 1'b0);
      step(2'd0, 1'b1, "R3 reload a", 2'd1, 24'hA70020);
      step(2'd0, 1'b1, "R3 reload eop", 2'd2, 24'hA70021);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_run();
      t_reject();
      t_wrap();
      t_page_map();
      t_gating();
      t_zero_count();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         summary();
         $finish;
      end
   end

endmodule